// File: doc/BRIEF.md
# Core Local-RAM Boot Loader

This block brings a processing core to life. On a launch request it copies a fixed-size program image, 512 words of 32 bits, from shared hub memory into the chosen core's private RAM. It then holds that core's run enable low for a short initialisation tail, and finally raises it. Shared memory is reached only through the target core's own time slot in a fixed 16-clock round-robin rotation. Loading therefore takes the same number of clocks every time and never takes bandwidth from other cores.

A launching core asks by raising a request with its own index, the target index and a hub byte start address. The request is taken only in the launcher's own hub slot, and only while no load is in progress. After a fixed launch overhead, one word is read per rotation and written into the target's RAM two clocks later. Twelve clocks after the last read the target is released, four clocks before its next hub window. After reset the block boots core 0 from a fixed address without any request.

Top module: `core_boot_loader`

## Requirements
- R1: `slot_phase` is 0 in the first cycle after reset and rises by one each clock, wrapping from 15 to 0; core k owns the hub window in cycles where `slot_phase` equals 2k.
- R2: Reset starts a load of core 0 from byte address 0x0010: `launch_busy` is high from the first cycle, and the first read falls 16 clocks after reset release.
- R3: A launch is accepted in a cycle where the block is idle, `launch_req` is high and `slot_phase` equals 2 × `launch_src`; `launch_busy` rises in the next cycle. A request in any other slot phase is not accepted.
- R4: Reads (`hub_rd_en` high for one cycle) occur only in the target's window. The first read is in the first such cycle at least 8 clocks after the acceptance cycle, and then one read follows every 16 clocks, exactly 512 in all.
- R5: Read i (from 0) uses `hub_rd_addr` = start address + 4·i, modulo 2^16.
- R6: Two clocks after read i, `ram_we` is high for one cycle with `ram_addr` = i, `ram_core` = target and `ram_wdata` = the `hub_rd_data` present in the cycle after the read.
- R7: Twelve clocks after the last read, `launch_busy` falls, `launch_done` pulses for one cycle and the target's `run_en` bit rises. This is 4 clocks before the target's next window.
- R8: Acceptance clears the target's `run_en` bit from the next cycle, and leaves the other bits unchanged.
- R9: A request made while `launch_busy` is high is ignored. Busy, reads, writes and run enables carry on as if it were absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_req | input | 1 | Launch request, held until busy is seen |
| launch_src | input | 3 | Index of the requesting core |
| launch_dst | input | 3 | Index of the core to start |
| launch_addr | input | 16 | Hub byte address of the image |
| launch_busy | output | 1 | Load in progress |
| launch_done | output | 1 | One-cycle pulse at release |
| slot_phase | output | 4 | Hub rotation position |
| hub_rd_en | output | 1 | Hub read strobe |
| hub_rd_addr | output | 16 | Hub read byte address |
| hub_rd_data | input | 32 | Hub read data, valid the cycle after the strobe |
| ram_we | output | 1 | Local RAM write strobe |
| ram_core | output | 3 | Core whose RAM is written |
| ram_addr | output | 9 | Local RAM word address |
| ram_wdata | output | 32 | Local RAM write data |
| run_en | output | 8 | Per-core run enable |

## Verification
The main load is tried with the reset boot of core 0, and with launches of cores 4 and 3 from core 0. Those two targets' slots straddle the 8-clock launch overhead, so one load waits a full extra rotation and the other does not, which separates a correct slot alignment from an off-by-one. One image starts at 0xFFF0, so the address must wrap to 0x0000 partway through. A relaunch of a running core from another launcher shows that only that core's enable drops. A request held during the boot load, across many slot phases, must leave every output trace unchanged.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef enum logic [1:0] {
    LD_IDLE,
    LD_LAUNCH,
    LD_XFER,
    LD_TAIL
  } ld_state_e;
endpackage

// File: rtl/hub_slot_counter.sv
module hub_slot_counter #(
  parameter int SLOTS = 16,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase,
  output logic [PW-1:0] phase_next
);
  always_comb begin
    phase_next = (phase == PW'(SLOTS - 1)) ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase_next;
  end

  // R1: rotation advances by exactly one position per clock
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase == (($past(phase) == PW'(SLOTS - 1)) ? '0 : $past(phase) + 1'b1)));
endmodule

// File: rtl/loader_seq.sv
module loader_seq
  import loader_pkg::*;
#(
  parameter int NUM_CORES   = 8,
  parameter int ADDR_W      = 16,
  parameter int LOAD_LONGS  = 512,
  parameter int LAUNCH_CLKS = 8,
  parameter int TAIL_CLKS   = 12,
  parameter int BOOT_CORE   = 0,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 16'h0010,
  localparam int CW    = $clog2(NUM_CORES),
  localparam int PW    = CW + 1,
  localparam int RAW   = $clog2(LOAD_LONGS),
  localparam int CNT_W = $clog2(LAUNCH_CLKS + TAIL_CLKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        phase,
  input  logic [PW-1:0]        phase_next,
  input  logic                 launch_req,
  input  logic [CW-1:0]        launch_src,
  input  logic [CW-1:0]        launch_dst,
  input  logic [ADDR_W-1:0]    launch_addr,
  output logic                 busy,
  output logic                 done,
  output logic                 rd_en,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic [RAW-1:0]       rd_idx,
  output logic [CW-1:0]        tgt,
  output logic [NUM_CORES-1:0] run_en
);
  ld_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [RAW-1:0]    rd_cnt;
  logic [ADDR_W-1:0] next_addr;
  logic              issue;
  logic              last;

  function automatic logic [PW-1:0] slot_of(input logic [CW-1:0] c);
    return {c, 1'b0};
  endfunction

  always_comb begin
    issue = ((state == LD_XFER) || (state == LD_LAUNCH && cnt == '0))
            && (phase_next == slot_of(tgt));
    last  = (rd_cnt == RAW'(LOAD_LONGS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LD_XFER;
      tgt       <= CW'(BOOT_CORE);
      next_addr <= BOOT_ADDR;
      rd_cnt    <= '0;
      cnt       <= '0;
      busy      <= 1'b1;
      done      <= 1'b0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      rd_idx    <= '0;
      run_en    <= '0;
    end else begin
      done  <= 1'b0;
      rd_en <= 1'b0;
      case (state)
        LD_IDLE: begin
          if (launch_req && phase == slot_of(launch_src)) begin
            state          <= LD_LAUNCH;
            cnt            <= CNT_W'(LAUNCH_CLKS - 2);
            tgt            <= launch_dst;
            next_addr      <= launch_addr;
            rd_cnt         <= '0;
            busy           <= 1'b1;
            run_en[launch_dst] <= 1'b0;
          end
        end
        LD_LAUNCH: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           state <= LD_XFER;
        end
        LD_TAIL: begin
          if (cnt == '0) begin
            state       <= LD_IDLE;
            busy        <= 1'b0;
            done        <= 1'b1;
            run_en[tgt] <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase
      if (issue) begin
        rd_en     <= 1'b1;
        rd_addr   <= next_addr;
        rd_idx    <= rd_cnt;
        next_addr <= next_addr + ADDR_W'(4);
        rd_cnt    <= rd_cnt + 1'b1;
        if (last) begin
          state <= LD_TAIL;
          cnt   <= CNT_W'(TAIL_CLKS - 1);
        end
      end
    end
  end

  // R4: hub reads stay inside the target's own window
  assert_read_in_slot_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (phase == slot_of(tgt)));

  // R3: a load only begins in response to a request
  assert_busy_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(launch_req));

  // R7: busy ends together with the done pulse and the enable of the target
  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && run_en[tgt]));

  // R7: the done pulse lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/ram_write_stage.sv
module ram_write_stage #(
  parameter int NUM_CORES  = 8,
  parameter int DATA_W     = 32,
  parameter int LOAD_LONGS = 512,
  localparam int CW  = $clog2(NUM_CORES),
  localparam int RAW = $clog2(LOAD_LONGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [RAW-1:0]    rd_idx,
  input  logic [CW-1:0]     tgt,
  input  logic [DATA_W-1:0] hub_rd_data,
  output logic              ram_we,
  output logic [RAW-1:0]    ram_addr,
  output logic [CW-1:0]     ram_core,
  output logic [DATA_W-1:0] ram_wdata
);
  logic           ret_v;
  logic [RAW-1:0] ret_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_v   <= 1'b0;
      ret_idx <= '0;
      ram_we  <= 1'b0;
    end else begin
      ret_v   <= rd_en;
      ret_idx <= rd_idx;
      ram_we  <= ret_v;
    end
  end

  always_ff @(posedge clk) begin
    ram_addr  <= ret_idx;
    ram_wdata <= hub_rd_data;
    ram_core  <= tgt;
  end

  // R6: every local write comes two clocks after a hub read
  assert_write_follows_read_R6: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(rd_en, 2));
endmodule

// File: rtl/core_boot_loader.sv
module core_boot_loader #(
  parameter int NUM_CORES   = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int LOAD_LONGS  = 512,
  parameter int LAUNCH_CLKS = 8,
  parameter int XFER_TAIL   = 8,
  parameter int INIT_CLKS   = 4,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 16'h0010,
  localparam int CW    = $clog2(NUM_CORES),
  localparam int SLOTS = 2 * NUM_CORES,
  localparam int PW    = $clog2(SLOTS),
  localparam int RAW   = $clog2(LOAD_LONGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 launch_req,
  input  logic [CW-1:0]        launch_src,
  input  logic [CW-1:0]        launch_dst,
  input  logic [ADDR_W-1:0]    launch_addr,
  output logic                 launch_busy,
  output logic                 launch_done,
  output logic [PW-1:0]        slot_phase,
  output logic                 hub_rd_en,
  output logic [ADDR_W-1:0]    hub_rd_addr,
  input  logic [DATA_W-1:0]    hub_rd_data,
  output logic                 ram_we,
  output logic [CW-1:0]        ram_core,
  output logic [RAW-1:0]       ram_addr,
  output logic [DATA_W-1:0]    ram_wdata,
  output logic [NUM_CORES-1:0] run_en
);
  logic [PW-1:0]  phase_next;
  logic [RAW-1:0] rd_idx;
  logic [CW-1:0]  tgt;

  hub_slot_counter #(.SLOTS(SLOTS)) u_slots (
    .clk        (clk),
    .rst        (rst),
    .phase      (slot_phase),
    .phase_next (phase_next)
  );

  loader_seq #(
    .NUM_CORES   (NUM_CORES),
    .ADDR_W      (ADDR_W),
    .LOAD_LONGS  (LOAD_LONGS),
    .LAUNCH_CLKS (LAUNCH_CLKS),
    .TAIL_CLKS   (XFER_TAIL + INIT_CLKS),
    .BOOT_CORE   (0),
    .BOOT_ADDR   (BOOT_ADDR)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .phase       (slot_phase),
    .phase_next  (phase_next),
    .launch_req  (launch_req),
    .launch_src  (launch_src),
    .launch_dst  (launch_dst),
    .launch_addr (launch_addr),
    .busy        (launch_busy),
    .done        (launch_done),
    .rd_en       (hub_rd_en),
    .rd_addr     (hub_rd_addr),
    .rd_idx      (rd_idx),
    .tgt         (tgt),
    .run_en      (run_en)
  );

  ram_write_stage #(
    .NUM_CORES  (NUM_CORES),
    .DATA_W     (DATA_W),
    .LOAD_LONGS (LOAD_LONGS)
  ) u_wr (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (hub_rd_en),
    .rd_idx      (rd_idx),
    .tgt         (tgt),
    .hub_rd_data (hub_rd_data),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_core    (ram_core),
    .ram_wdata   (ram_wdata)
  );
endmodule

// File: tb/core_boot_loader_bench.sv
`timescale 1ns/1ps
module core_boot_loader_bench;
  localparam int NC = 8;
  localparam int SL = 16;
  localparam int LONGS = 512;
  localparam int BOOT = 16'h0010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        launch_req = 1'b0;
  logic [2:0]  launch_src = '0;
  logic [2:0]  launch_dst = '0;
  logic [15:0] launch_addr = '0;
  logic        launch_busy, launch_done, hub_rd_en, ram_we;
  logic [3:0]  slot_phase;
  logic [15:0] hub_rd_addr;
  logic [31:0] hub_rd_data = '0;
  logic [2:0]  ram_core;
  logic [8:0]  ram_addr;
  logic [31:0] ram_wdata;
  logic [NC-1:0] run_en;

  always #4 clk = ~clk;

  core_boot_loader u_core_boot_loader (
    .clk(clk), .rst(rst), .launch_req(launch_req), .launch_src(launch_src),
    .launch_dst(launch_dst), .launch_addr(launch_addr), .launch_busy(launch_busy),
    .launch_done(launch_done), .slot_phase(slot_phase), .hub_rd_en(hub_rd_en),
    .hub_rd_addr(hub_rd_addr), .hub_rd_data(hub_rd_data), .ram_we(ram_we),
    .ram_core(ram_core), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .run_en(run_en)
  );

  function automatic logic [31:0] hub_word(input int a);
    return {16'(a) ^ 16'hA5C3, 16'(a)};
  endfunction

  // shared hub memory with one clock of read latency
  always @(posedge clk) if (hub_rd_en) hub_rd_data <= hub_word(int'(hub_rd_addr));

  int cyc = 0;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  // reference model of the current load (boot load at start)
  int t_core = 0, t_base = BOOT, t_c = -1, t_f = SL;
  int t_rel = SL + (LONGS - 1) * SL + 12;
  string t_tag = "R2";
  logic [NC-1:0] e_run = '0;
  bit req_busy_prev = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int k;
      bit e_rd, e_we;
      int i, j;
      string bt;
      k = cyc;
      bt = req_busy_prev ? "R9" : t_tag;
      if (k == t_rel) e_run[t_core] = 1'b1;
      check("R1", slot_phase, k % SL);
      check(bt, launch_busy, (k >= t_c + 1 && k < t_rel));
      i = (k - t_f) / SL;
      e_rd = (k >= t_f) && ((k - t_f) % SL == 0) && (i < LONGS);
      check("R4", hub_rd_en, e_rd);
      if (e_rd) check("R5", hub_rd_addr, (t_base + 4 * i) & 16'hFFFF);
      j = (k - t_f - 2) / SL;
      e_we = (k >= t_f + 2) && ((k - t_f - 2) % SL == 0) && (j < LONGS);
      check("R6", ram_we, e_we);
      if (e_we) begin
        check("R6", ram_addr, j);
        check("R6", ram_core, t_core);
        check("R6", ram_wdata, hub_word((t_base + 4 * j) & 16'hFFFF));
      end
      check("R7", launch_done, k == t_rel);
      check(req_busy_prev ? "R9" : "R8", run_en, e_run);
      req_busy_prev = launch_req && (k < t_rel);
      if (k >= t_rel && launch_req && (k % SL) == 2 * int'(launch_src)) begin
        int m;
        t_c = k;
        t_core = int'(launch_dst);
        t_base = int'(launch_addr);
        m = k + 8;
        while ((m % SL) != 2 * t_core) m++;
        t_f = m;
        t_rel = t_f + (LONGS - 1) * SL + 12;
        e_run[t_core] = 1'b0;
        t_tag = "R3";
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (launch_done !== 1'b1);
  endtask

  task automatic launch(input int src, input int dst, input int addr);
    @(posedge clk); #1;
    launch_req = 1'b1; launch_src = 3'(src); launch_dst = 3'(dst); launch_addr = 16'(addr);
    do @(negedge clk); while (launch_busy !== 1'b1);
    @(posedge clk); #1;
    launch_req = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (100) @(posedge clk);
    #1;  // R9: request held while the boot load is running
    launch_req = 1'b1; launch_src = 3'd1; launch_dst = 3'd3; launch_addr = 16'h0400;
    repeat (40) @(posedge clk);
    #1 launch_req = 1'b0;
    wait_done();
    launch(0, 4, 16'h1000);   // R3 R4: target slot after launch overhead
    wait_done();
    launch(0, 3, 16'hFFF0);   // R4 R5: slot missed, address wraps
    wait_done();
    launch(2, 4, 16'h0200);   // R8: relaunch of a running core
    wait_done();
    repeat (20) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R7: actual no finish expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule